// File: doc/BRIEF.md
# I2C Register-Pointer Slave

This block is the serial front end of a small peripheral whose registers are 16 bits wide. It oversamples the SCL and SDA lines from the system clock and recognises the bus framing conditions. It answers one fixed 7-bit device address and pulls SDA low through an output-enable when it must drive a zero. The register file behind it sees a pointer, a write word with a per-byte enable and a one-cycle write strobe, and it returns a combinational read word for the register the pointer selects.

A write transaction always carries the pointer in its first data byte. Any data bytes after it arrive in pairs, high byte first, and each byte is written to the pointed register as soon as it has been received. The pointer is kept between transactions. A read that begins directly after the address byte therefore returns the register chosen last. Reads send the high byte first. While the master keeps acknowledging, the slave repeats the same register, high byte then low byte, with no limit. Standard and Fast mode bus speeds are supported as long as the system clock is fast enough to oversample them.

Top module: `i2c_reg_slave`

## Requirements
- R1: SDA falling while SCL is high is a Start. It restarts address reception from any state, including in the middle of a write or a read (Repeated Start).
- R2: SDA rising while SCL is high is a Stop. It releases SDA, and the slave drives nothing until the next Start.
- R3: The address byte carries the 7-bit address in its upper bits and the direction in bit 0, where 1 means read. A match with `DEV_ADDR` is acknowledged by driving SDA low on the ninth clock. On a mismatch SDA stays released, and all bytes up to the next Start or Stop are ignored: no acknowledge, no strobe and no change to the pointer.
- R4: The first data byte of a write is acknowledged and loaded into `reg_ptr`. The pointer keeps its value across Stop and Start until the next write loads it again.
- R5: A high data byte is acknowledged and produces a one-cycle `wr_strb` with `wr_be` = 2'b10 and the byte on `wr_data[15:8]`. A Stop after it ends a single-byte write.
- R6: A low data byte is acknowledged and produces a one-cycle `wr_strb` with `wr_be` = 2'b01 and `wr_data` = {preceding high byte, low byte}. Further byte pairs go to the same pointer, which does not advance.
- R7: After a read address, the slave sends the high byte of `rd_data` and then the low byte, each MSB first.
- R8: A master ACK (SDA low on the ninth clock) after the low byte makes the slave send the high byte of a fresh sample again. A master NACK after any byte stops all driving until the next Start or Stop.
- R9: The read word is captured when its high byte is loaded. The low byte that follows comes from that same capture, even if `rd_data` has changed in the meantime.
- R10: SDA is sampled on SCL rising edges. `sda_oe` (1 = pull SDA low) changes only while SCL is low.
- R11: After reset, `sda_oe` = 0, `wr_strb` = 0 and `reg_ptr` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, several times faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| reg_ptr | output | PTR_W | Register pointer held between transactions |
| wr_data | output | 16 | Write word, high byte in [15:8] |
| wr_be | output | 2 | Byte enable: bit 1 for the high byte, bit 0 for the low byte |
| wr_strb | output | 1 | One-cycle write pulse |
| rd_data | input | 16 | Word of the register that `reg_ptr` selects |

## Verification
Two things can happen in the same cycle during a streaming read. The register file can update the pointed register, and the slave can load a byte from the word it captured earlier. The bench overwrites the register in its model between the high-byte and low-byte transfers. It expects the low byte to come from the older capture and the next high byte to carry the new value. The same idea of overlap applies to a Repeated Start that cuts off a write or read mid-stream. The bench checks that the Repeated Start is honoured without a Stop in between.

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave #(
  parameter logic [6:0] DEV_ADDR = 7'h48,
  parameter int         PTR_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [PTR_W-1:0]  reg_ptr,
  output logic [15:0]       wr_data,
  output logic [1:0]        wr_be,
  output logic              wr_strb,
  input  logic [15:0]       rd_data
);
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W);

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_ADDR_ACK, S_PTR, S_PTR_ACK, S_WHI, S_WHI_ACK,
    S_WLO, S_WLO_ACK, S_RD, S_RD_ACK, S_WAIT
  } st_t;

  st_t               st;
  logic [2:0]        scl_p, sda_p;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] sh, tx;
  logic [15:0]       hold;
  logic              rnw, lo_next, mack;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
    end else begin
      scl_p <= {scl_p[1:0], scl_i};
      sda_p <= {sda_p[1:0], sda_i};
    end

  wire scl_s     = scl_p[1];
  wire sda_s     = sda_p[1];
  wire scl_rise  = scl_s & ~scl_p[2];
  wire scl_fall  = ~scl_s & scl_p[2];
  wire start_det = scl_s & scl_p[2] & sda_p[2] & ~sda_s;
  wire stop_det  = scl_s & scl_p[2] & ~sda_p[2] & sda_s;
  wire rx_state  = (st == S_ADDR) || (st == S_PTR) || (st == S_WHI) || (st == S_WLO);
  wire rd_phase  = (st == S_RD) || (st == S_RD_ACK);
  wire byte_done = scl_fall && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      sh      <= '0;
      tx      <= '0;
      hold    <= '0;
      rnw     <= 1'b0;
      lo_next <= 1'b0;
      mack    <= 1'b0;
      sda_oe  <= 1'b0;
      reg_ptr <= '0;
      wr_data <= '0;
      wr_be   <= '0;
      wr_strb <= 1'b0;
    end else begin
      wr_strb <= 1'b0;
      if (start_det) begin
        st     <= S_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        st     <= S_IDLE;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (rx_state) begin
        if (scl_rise) begin
          sh  <= {sh[BYTE_W-2:0], sda_s};
          cnt <= cnt + 1'b1;
        end else if (byte_done) begin
          cnt <= '0;
          case (st)
            S_ADDR:
              if (sh[7:1] == DEV_ADDR) begin
                sda_oe <= 1'b1;
                rnw    <= sh[0];
                st     <= S_ADDR_ACK;
              end else begin
                st <= S_WAIT;
              end
            S_PTR: begin
              sda_oe  <= 1'b1;
              reg_ptr <= sh[PTR_W-1:0];
              st      <= S_PTR_ACK;
            end
            S_WHI: begin
              sda_oe        <= 1'b1;
              wr_data[15:8] <= sh;
              wr_be         <= 2'b10;
              wr_strb       <= 1'b1;
              st            <= S_WHI_ACK;
            end
            default: begin
              sda_oe       <= 1'b1;
              wr_data[7:0] <= sh;
              wr_be        <= 2'b01;
              wr_strb      <= 1'b1;
              st           <= S_WLO_ACK;
            end
          endcase
        end
      end else begin
        case (st)
          S_ADDR_ACK:
            if (scl_fall) begin
              if (rnw) begin
                hold    <= rd_data;
                tx      <= rd_data[15:8];
                sda_oe  <= ~rd_data[15];
                lo_next <= 1'b1;
                st      <= S_RD;
              end else begin
                sda_oe <= 1'b0;
                st     <= S_PTR;
              end
            end
          S_PTR_ACK: if (scl_fall) begin sda_oe <= 1'b0; st <= S_WHI; end
          S_WHI_ACK: if (scl_fall) begin sda_oe <= 1'b0; st <= S_WLO; end
          S_WLO_ACK: if (scl_fall) begin sda_oe <= 1'b0; st <= S_WHI; end
          S_RD:
            if (scl_rise) begin
              cnt <= cnt + 1'b1;
            end else if (byte_done) begin
              cnt    <= '0;
              sda_oe <= 1'b0;
              st     <= S_RD_ACK;
            end else if (scl_fall) begin
              tx     <= {tx[BYTE_W-2:0], 1'b0};
              sda_oe <= ~tx[BYTE_W-2];
            end
          S_RD_ACK:
            if (scl_rise) begin
              mack <= ~sda_s;
            end else if (scl_fall) begin
              if (!mack) begin
                st <= S_WAIT;
              end else if (lo_next) begin
                tx      <= hold[7:0];
                sda_oe  <= ~hold[7];
                lo_next <= 1'b0;
                st      <= S_RD;
              end else begin
                hold    <= rd_data;
                tx      <= rd_data[15:8];
                sda_oe  <= ~rd_data[15];
                lo_next <= 1'b1;
                st      <= S_RD;
              end
            end
          default: ;
        endcase
      end
    end
endmodule

// File: rtl/i2c_reg_slave_chk.sv
module i2c_reg_slave_chk #(
  parameter int PW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_s,
  input logic          sda_oe,
  input logic          wr_strb,
  input logic [1:0]    wr_be,
  input logic          start_det,
  input logic          stop_det,
  input logic          rd_phase,
  input logic [PW-1:0] reg_ptr
);
  AST_OE_ONLY_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(sda_oe) |-> !scl_s); // R10
  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe); // R2
  AST_START_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !sda_oe); // R1
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strb |=> !wr_strb); // R5
  AST_BE_ONE_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strb |-> $countones(wr_be) == 1); // R6
  AST_READ_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_phase |-> !wr_strb); // R7
  AST_READ_PTR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_phase |=> $stable(reg_ptr)); // R4
endmodule

bind i2c_reg_slave i2c_reg_slave_chk #(.PW(PTR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe),
  .wr_strb(wr_strb), .wr_be(wr_be), .start_det(start_det),
  .stop_det(stop_det), .rd_phase(rd_phase), .reg_ptr(reg_ptr)
);

// File: tb/i2c_reg_slave_tb_top.sv
module i2c_reg_slave_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 8;
  localparam logic [7:0] AW = 8'h90, AR = 8'h91, ABAD = 8'h84;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, m_low = 1'b0;
  logic sda_oe, wr_strb;
  logic [7:0]  reg_ptr;
  logic [15:0] wr_data, rd_data;
  logic [1:0]  wr_be;
  wire sda_line = !(m_low || sda_oe);

  logic [15:0] mem [0:255];
  logic [15:0] s_data [0:15];
  logic [1:0]  s_be [0:15];
  int ns = 0, tests = 0, fails = 0, viol = 0;
  logic prev_oe = 1'b0, done = 1'b0;
  logic poke_en = 1'b0;
  logic [7:0] poke_a = '0;
  logic [15:0] poke_v = '0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign rd_data = mem[reg_ptr];

  i2c_reg_slave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .reg_ptr(reg_ptr), .wr_data(wr_data),
    .wr_be(wr_be), .wr_strb(wr_strb), .rd_data(rd_data)
  );

  always @(negedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] = {8'(i) ^ 8'hC3, 8'(i)};
    end else begin
      if (wr_strb) begin
        if (ns < 16) begin s_data[ns] = wr_data; s_be[ns] = wr_be; end
        ns++;
        if (wr_be[1]) mem[reg_ptr][15:8] = wr_data[15:8];
        if (wr_be[0]) mem[reg_ptr][7:0]  = wr_data[7:0];
      end
      if (poke_en) mem[poke_a] = poke_v;
      if (sda_oe !== prev_oe && scl_m) viol++;
    end
    prev_oe = sda_oe;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wt(input int n); repeat (n) @(negedge clk); endtask

  task automatic bus_start;
    m_low = 1'b0; wt(Q); scl_m = 1'b1; wt(Q); m_low = 1'b1; wt(Q); scl_m = 1'b0; wt(Q);
  endtask

  task automatic bus_stop;
    m_low = 1'b1; wt(Q); scl_m = 1'b1; wt(Q); m_low = 1'b0; wt(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_low = ~b[i]; wt(Q); scl_m = 1'b1; wt(2*Q); scl_m = 1'b0; wt(Q);
    end
    m_low = 1'b0; wt(Q); scl_m = 1'b1; wt(Q); ack = !sda_line; wt(Q); scl_m = 1'b0; wt(Q);
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    m_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      wt(Q); scl_m = 1'b1; wt(Q); b[i] = sda_line; wt(Q); scl_m = 1'b0;
    end
    wt(Q); m_low = give_ack; wt(Q); scl_m = 1'b1; wt(2*Q); scl_m = 1'b0; wt(1); m_low = 1'b0;
  endtask

  task automatic t_reset;
    chk(sda_oe == 1'b0, "R11 sda_oe", 32'(sda_oe), 0);
    chk(wr_strb == 1'b0, "R11 wr_strb", 32'(wr_strb), 0);
    chk(reg_ptr == 8'h00, "R11 reg_ptr", 32'(reg_ptr), 0);
  endtask

  task automatic t_addr_mismatch;
    logic a;
    int n0 = ns;
    bus_start; send_byte(ABAD, a);
    chk(a == 1'b0, "R3 mismatch nack", 32'(a), 0);
    send_byte(8'h5A, a);
    chk(a == 1'b0, "R3 ignored byte nack", 32'(a), 0);
    bus_stop;
    chk(reg_ptr == 8'h00, "R3 pointer untouched", 32'(reg_ptr), 0);
    chk(ns == n0, "R3 no strobe", 32'(ns), 32'(n0));
  endtask

  task automatic t_set_ptr;
    logic a1, a2;
    bus_start; send_byte(AW, a1); send_byte(8'h05, a2); bus_stop;
    chk(a1 == 1'b1, "R3 match ack", 32'(a1), 1);
    chk(a2 == 1'b1, "R4 pointer ack", 32'(a2), 1);
    chk(reg_ptr == 8'h05, "R4 pointer loaded", 32'(reg_ptr), 5);
  endtask

  task automatic t_single_write;
    logic a;
    int n0 = ns;
    bus_start; send_byte(AW, a); send_byte(8'h03, a); send_byte(8'hA5, a);
    chk(a == 1'b1, "R5 high byte ack", 32'(a), 1);
    bus_stop;
    chk(ns == n0 + 1, "R5 one strobe", 32'(ns), 32'(n0 + 1));
    chk(s_be[n0] == 2'b10 && s_data[n0][15:8] == 8'hA5, "R5 upper write",
        {14'h0, s_be[n0], s_data[n0]}, {16'h2, 16'hA500} | 32'(s_data[n0][7:0]));
    chk(sda_oe == 1'b0, "R2 released after stop", 32'(sda_oe), 0);
  endtask

  task automatic t_pair_write;
    logic a;
    int n0 = ns;
    bus_start; send_byte(AW, a); send_byte(8'h07, a);
    send_byte(8'h12, a); send_byte(8'h34, a); send_byte(8'h56, a); send_byte(8'h78, a);
    chk(a == 1'b1, "R6 low byte ack", 32'(a), 1);
    bus_stop;
    chk(ns == n0 + 4, "R6 four strobes", 32'(ns), 32'(n0 + 4));
    chk(s_be[n0+1] == 2'b01 && s_data[n0+1] == 16'h1234, "R6 first pair",
        {14'h0, s_be[n0+1], s_data[n0+1]}, 32'h0001_1234);
    chk(s_be[n0+3] == 2'b01 && s_data[n0+3] == 16'h5678, "R6 second pair",
        {14'h0, s_be[n0+3], s_data[n0+3]}, 32'h0001_5678);
    chk(reg_ptr == 8'h07, "R6 pointer not advanced", 32'(reg_ptr), 7);
  endtask

  task automatic t_rstart_read;
    logic a;
    logic [7:0] hi, lo, ex;
    bus_start; send_byte(AW, a); send_byte(8'h07, a);
    bus_start; send_byte(AR, a);
    chk(a == 1'b1, "R1 read address after restart", 32'(a), 1);
    recv_byte(1'b1, hi); recv_byte(1'b0, lo);
    chk({hi, lo} == 16'h5678, "R7 read after restart", {hi, lo}, 32'h5678);
    recv_byte(1'b0, ex);
    chk(ex == 8'hFF, "R8 silent after nack", 32'(ex), 32'hFF);
    bus_stop;
  endtask

  task automatic t_preset_read;
    logic a;
    logic [7:0] hi, lo;
    bus_start; send_byte(AR, a); recv_byte(1'b1, hi); recv_byte(1'b0, lo); bus_stop;
    chk({hi, lo} == 16'h5678, "R4 R7 read with kept pointer", {hi, lo}, 32'h5678);
  endtask

  task automatic t_write_then_restart;
    logic a;
    logic [7:0] hi, lo;
    bus_start; send_byte(AW, a); send_byte(8'h02, a); send_byte(8'h11, a);
    bus_start; send_byte(AR, a); recv_byte(1'b1, hi); recv_byte(1'b0, lo); bus_stop;
    chk({hi, lo} == 16'h1102, "R1 restart after high byte", {hi, lo}, 32'h1102);
  endtask

  task automatic t_stream;
    logic a;
    logic [7:0] b0, b1, b2, b3;
    bus_start; send_byte(AW, a); send_byte(8'h09, a);
    send_byte(8'hBE, a); send_byte(8'hEF, a); bus_stop;
    bus_start; send_byte(AR, a); recv_byte(1'b1, b0);
    @(posedge clk); poke_a = 8'h09; poke_v = 16'h1234; poke_en = 1'b1;
    @(posedge clk); poke_en = 1'b0;
    recv_byte(1'b1, b1); recv_byte(1'b1, b2); recv_byte(1'b0, b3); bus_stop;
    chk(b0 == 8'hBE, "R7 stream high", 32'(b0), 32'hBE);
    chk(b1 == 8'hEF, "R9 low byte from capture", 32'(b1), 32'hEF);
    chk({b2, b3} == 16'h1234, "R8 repeated word fresh", {b2, b3}, 32'h1234);
  endtask

  initial begin
    wt(5); rst_n = 1'b1; wt(5);
    t_reset;
    t_addr_mismatch;
    t_set_ptr;
    t_single_write;
    t_pair_write;
    t_rstart_read;
    t_preset_read;
    t_write_then_restart;
    t_stream;
    chk(viol == 0, "R10 sda_oe moved with SCL high", 32'(viol), 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule